// File: doc/BRIEF.md
# Virtualization Intercept Decision Unit

This unit decides, for one guest event at a time, whether the event must leave the guest and return control to the hypervisor. A requester presents a 32-bit exit-type code and a 64-bit parameter with a valid strobe. One clock later the unit raises a done strobe. When the event is intercepted, it also raises an exit request, and it returns the code and the parameter as the exit code and the exit-info value.

The intercept state is held in six registers, all written together by a load strobe on guest entry:
- an enable flag;
- a 64-bit general intercept vector;
- read and write masks for control registers;
- read and write masks for debug registers;
- a 32-bit exception mask.

A clear strobe on guest exit zeroes the enable flag, the general vector and the exception mask.

The exit code space is divided into ranged classes. Each class tests one bit of its own mask, at the code's offset from the class base. Every other code falls back to the general vector, indexed from an interrupt base code. For model-specific-register accesses, the permission-map lookup is done outside this unit. Its verdict arrives on `msr_deny_i` together with the check, and it is used only when the general-vector bit for the MSR code is set.

Top module: `intc_decide_top`

## Requirements
- R1: While reset is held and after its release, `done_o` and `exit_o` are 0. `exit_code_o` and `exit_info_o` are 0 until the first check. All intercept registers reset to zero.
- R2: When the enable flag is 0, `exit_o` stays 0 for every code, whatever the masks and `msr_deny_i` hold.
- R3: Codes from CR_RD_BASE (0x000) to CR_RD_BASE+8 exit exactly when the CR-read mask bit at index (code − CR_RD_BASE) is 1. Codes from CR_WR_BASE (0x010) to CR_WR_BASE+8 use the CR-write mask in the same way.
- R4: Codes from DR_RD_BASE (0x020) to DR_RD_BASE+7 test DR-read mask bit (code − DR_RD_BASE). Codes from DR_WR_BASE (0x030) to DR_WR_BASE+7 test the DR-write mask the same way. Mask bits 8 to 15 never cause an exit.
- R5: Codes from EXC_BASE (0x040) to EXC_BASE+31 exit exactly when exception-mask bit (code − EXC_BASE) is 1.
- R6: Any other code in INTR_BASE (0x060) to INTR_BASE+63, apart from the MSR code, tests general-vector bit (code − INTR_BASE). A code in none of the ranges never exits. This includes the gaps between classes, such as 0x009–0x00F and 0x028–0x02F, and every code from 0x0A0 upward.
- R7: The MSR code (MSR_CODE, 0x07C, general bit 28) exits only when general-vector bit 28 is 1 and `msr_deny_i` is 1. With bit 28 at 0, `msr_deny_i` is ignored.
- R8: `done_o` is a one-cycle pulse in the cycle after each cycle with `chk_valid_i` high, and is 0 otherwise. `exit_o` is high only together with `done_o`.
- R9: On each check, `exit_code_o` and `exit_info_o` take the check's code and parameter, and they hold until the next check.
- R10: A load takes effect for checks presented from the cycle after the load strobe. A check presented in the same cycle as a load is decided on the previous register contents.
- R11: A clear zeroes the enable flag, the general vector and the exception mask in one cycle. A clear has priority over a load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Write all intercept registers (guest entry) |
| ld_enable_i | input | 1 | Enable flag to load |
| ld_gen_i | input | 64 | General intercept vector to load |
| ld_cr_rd_i | input | 16 | CR-read mask to load |
| ld_cr_wr_i | input | 16 | CR-write mask to load |
| ld_dr_rd_i | input | 16 | DR-read mask to load |
| ld_dr_wr_i | input | 16 | DR-write mask to load |
| ld_exc_i | input | 32 | Exception mask to load |
| clear_i | input | 1 | Zero enable, general vector and exception mask (guest exit) |
| chk_valid_i | input | 1 | Check request |
| chk_code_i | input | 32 | Exit-type code under test |
| chk_param_i | input | 64 | Parameter carried into exit info |
| msr_deny_i | input | 1 | Permission-map verdict for an MSR access |
| done_o | output | 1 | Decision strobe |
| exit_o | output | 1 | Exit requested |
| exit_code_o | output | 32 | Exit code of the last check |
| exit_info_o | output | 64 | Exit info of the last check |

## Verification
The bench sweeps every code from 0x000 to 0x0BF and some far codes, under complementary mask patterns. Mask bits lying beyond each class span are set on purpose. If the range tests were off by one, codes such as 0x009, 0x028 or 0x0A0 would exit, or would fall into the wrong mask. The MSR code is tried with each combination of general bit 28 and the deny input; a unit that skipped the gating would let the deny input alone cause exits. Load, clear and check are also made to coincide. A unit that decided on freshly loaded values, or let load beat clear, would then report exits one cycle too early or after guest exit.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned CODE_W  = 32;
  localparam int unsigned INFO_W  = 64;
  localparam int unsigned VEC_W   = 64;
  localparam int unsigned NUM_CLS = 6;

  // class slots in the decoder; the general class must be last
  typedef enum logic [2:0] {
    CLS_CR_RD = 3'd0,
    CLS_CR_WR = 3'd1,
    CLS_DR_RD = 3'd2,
    CLS_DR_WR = 3'd3,
    CLS_EXC   = 3'd4,
    CLS_GEN   = 3'd5
  } cls_e;
endpackage

// File: rtl/intc_range_sel.sv
module intc_range_sel #(
  parameter int unsigned CODE_W = 32,
  parameter int unsigned VEC_W  = 64,
  parameter int unsigned BASE   = 0,
  parameter int unsigned SPAN   = 9
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic              in_range_o,
  output logic              sel_bit_o
);
  localparam int unsigned IDX_W = $clog2(VEC_W);

  logic [CODE_W-1:0] rel;
  logic [IDX_W-1:0]  idx;

  // unsigned wrap makes codes below BASE compare as large
  always_comb begin
    rel        = code_i - CODE_W'(BASE);
    in_range_o = (rel < CODE_W'(SPAN));
    idx        = rel[IDX_W-1:0];
    sel_bit_o  = in_range_o & vec_i[idx];
  end
endmodule

// File: rtl/intc_mask_regs.sv
module intc_mask_regs
  import intc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic             ld_enable_i,
  input  logic [VEC_W-1:0] ld_gen_i,
  input  logic [15:0]      ld_cr_rd_i,
  input  logic [15:0]      ld_cr_wr_i,
  input  logic [15:0]      ld_dr_rd_i,
  input  logic [15:0]      ld_dr_wr_i,
  input  logic [31:0]      ld_exc_i,
  output logic             en_q,
  output logic [VEC_W-1:0] gen_q,
  output logic [15:0]      cr_rd_q,
  output logic [15:0]      cr_wr_q,
  output logic [15:0]      dr_rd_q,
  output logic [15:0]      dr_wr_q,
  output logic [31:0]      exc_q
);
  logic             en_d;
  logic [VEC_W-1:0] gen_d;
  logic [15:0]      cr_rd_d, cr_wr_d, dr_rd_d, dr_wr_d;
  logic [31:0]      exc_d;
  logic             mask_we;

  always_comb begin
    en_d    = en_q;
    gen_d   = gen_q;
    exc_d   = exc_q;
    mask_we = load_i;
    if (load_i) begin
      en_d  = ld_enable_i;
      gen_d = ld_gen_i;
      exc_d = ld_exc_i;
    end
    // guest exit wins over a coincident entry
    if (clear_i) begin
      en_d  = 1'b0;
      gen_d = '0;
      exc_d = '0;
    end
    cr_rd_d = mask_we ? ld_cr_rd_i : cr_rd_q;
    cr_wr_d = mask_we ? ld_cr_wr_i : cr_wr_q;
    dr_rd_d = mask_we ? ld_dr_rd_i : dr_rd_q;
    dr_wr_d = mask_we ? ld_dr_wr_i : dr_wr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      gen_q   <= '0;
      exc_q   <= '0;
      cr_rd_q <= '0;
      cr_wr_q <= '0;
      dr_rd_q <= '0;
      dr_wr_q <= '0;
    end else begin
      en_q    <= en_d;
      gen_q   <= gen_d;
      exc_q   <= exc_d;
      cr_rd_q <= cr_rd_d;
      cr_wr_q <= cr_wr_d;
      dr_rd_q <= dr_rd_d;
      dr_wr_q <= dr_wr_d;
    end
  end

  // R11: clear leaves nothing that could request an exit
  p_clear_zeroes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!en_q && gen_q == '0 && exc_q == '0));

  // R10: load without clear installs the supplied enable
  p_load_installs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clear_i) |=> (en_q == $past(ld_enable_i)));
endmodule

// File: rtl/intc_class_decode.sv
module intc_class_decode
  import intc_pkg::*;
#(
  parameter int unsigned CR_RD_BASE = 32'h000,
  parameter int unsigned CR_WR_BASE = 32'h010,
  parameter int unsigned DR_RD_BASE = 32'h020,
  parameter int unsigned DR_WR_BASE = 32'h030,
  parameter int unsigned EXC_BASE   = 32'h040,
  parameter int unsigned INTR_BASE  = 32'h060,
  parameter int unsigned MSR_CODE   = 32'h07C
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [VEC_W-1:0]  gen_i,
  input  logic [15:0]       cr_rd_i,
  input  logic [15:0]       cr_wr_i,
  input  logic [15:0]       dr_rd_i,
  input  logic [15:0]       dr_wr_i,
  input  logic [31:0]       exc_i,
  input  logic              msr_deny_i,
  output logic [NUM_CLS-1:0] cls_hit_o,
  output logic              hit_o
);
  localparam int unsigned CLS_BASE [NUM_CLS] =
    '{CR_RD_BASE, CR_WR_BASE, DR_RD_BASE, DR_WR_BASE, EXC_BASE, INTR_BASE};
  localparam int unsigned CLS_SPAN [NUM_CLS] = '{9, 9, 8, 8, 32, VEC_W};
  localparam int unsigned MSR_IDX  = MSR_CODE - INTR_BASE;

  logic [VEC_W-1:0]   vecs   [NUM_CLS];
  logic [NUM_CLS-1:0] in_rng;
  logic [NUM_CLS-1:0] sel;
  logic               special_any;
  logic               is_msr;

  always_comb begin
    vecs[CLS_CR_RD] = {{(VEC_W-16){1'b0}}, cr_rd_i};
    vecs[CLS_CR_WR] = {{(VEC_W-16){1'b0}}, cr_wr_i};
    vecs[CLS_DR_RD] = {{(VEC_W-16){1'b0}}, dr_rd_i};
    vecs[CLS_DR_WR] = {{(VEC_W-16){1'b0}}, dr_wr_i};
    vecs[CLS_EXC]   = {{(VEC_W-32){1'b0}}, exc_i};
    vecs[CLS_GEN]   = gen_i;
  end

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
    intc_range_sel #(
      .CODE_W(CODE_W), .VEC_W(VEC_W),
      .BASE(CLS_BASE[g]), .SPAN(CLS_SPAN[g])
    ) u_sel (
      .code_i    (code_i),
      .vec_i     (vecs[g]),
      .in_range_o(in_rng[g]),
      .sel_bit_o (sel[g])
    );
  end

  always_comb begin
    special_any = |in_rng[NUM_CLS-2:0];
    is_msr      = (code_i == CODE_W'(MSR_CODE));
    cls_hit_o   = in_rng;
    // general class only catches codes no ranged class claims
    cls_hit_o[CLS_GEN] = in_rng[CLS_GEN] & ~special_any;
    if (is_msr)
      hit_o = gen_i[MSR_IDX] & msr_deny_i;
    else
      hit_o = (|sel[NUM_CLS-2:0]) | (sel[CLS_GEN] & ~special_any);
  end
endmodule

// File: rtl/intc_decide_top.sv
module intc_decide_top
  import intc_pkg::*;
#(
  parameter int unsigned CR_RD_BASE = 32'h000,
  parameter int unsigned CR_WR_BASE = 32'h010,
  parameter int unsigned DR_RD_BASE = 32'h020,
  parameter int unsigned DR_WR_BASE = 32'h030,
  parameter int unsigned EXC_BASE   = 32'h040,
  parameter int unsigned INTR_BASE  = 32'h060,
  parameter int unsigned MSR_CODE   = 32'h07C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic        ld_enable_i,
  input  logic [63:0] ld_gen_i,
  input  logic [15:0] ld_cr_rd_i,
  input  logic [15:0] ld_cr_wr_i,
  input  logic [15:0] ld_dr_rd_i,
  input  logic [15:0] ld_dr_wr_i,
  input  logic [31:0] ld_exc_i,
  input  logic        clear_i,
  input  logic        chk_valid_i,
  input  logic [31:0] chk_code_i,
  input  logic [63:0] chk_param_i,
  input  logic        msr_deny_i,
  output logic        done_o,
  output logic        exit_o,
  output logic [31:0] exit_code_o,
  output logic [63:0] exit_info_o
);
  localparam int unsigned MSR_IDX = MSR_CODE - INTR_BASE;

  logic             en_q;
  logic [VEC_W-1:0] gen_q;
  logic [15:0]      cr_rd_q, cr_wr_q, dr_rd_q, dr_wr_q;
  logic [31:0]      exc_q;
  logic [NUM_CLS-1:0] cls_hit;
  logic             class_hit;

  logic              done_d, exit_d;
  logic [CODE_W-1:0] code_d, code_q;
  logic [INFO_W-1:0] info_d, info_q;
  logic              done_q, exit_q;

  intc_mask_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .load_i(load_i), .clear_i(clear_i),
    .ld_enable_i(ld_enable_i), .ld_gen_i(ld_gen_i),
    .ld_cr_rd_i(ld_cr_rd_i), .ld_cr_wr_i(ld_cr_wr_i),
    .ld_dr_rd_i(ld_dr_rd_i), .ld_dr_wr_i(ld_dr_wr_i),
    .ld_exc_i(ld_exc_i),
    .en_q(en_q), .gen_q(gen_q),
    .cr_rd_q(cr_rd_q), .cr_wr_q(cr_wr_q),
    .dr_rd_q(dr_rd_q), .dr_wr_q(dr_wr_q),
    .exc_q(exc_q)
  );

  intc_class_decode #(
    .CR_RD_BASE(CR_RD_BASE), .CR_WR_BASE(CR_WR_BASE),
    .DR_RD_BASE(DR_RD_BASE), .DR_WR_BASE(DR_WR_BASE),
    .EXC_BASE(EXC_BASE), .INTR_BASE(INTR_BASE), .MSR_CODE(MSR_CODE)
  ) u_dec (
    .code_i(chk_code_i), .gen_i(gen_q),
    .cr_rd_i(cr_rd_q), .cr_wr_i(cr_wr_q),
    .dr_rd_i(dr_rd_q), .dr_wr_i(dr_wr_q),
    .exc_i(exc_q), .msr_deny_i(msr_deny_i),
    .cls_hit_o(cls_hit), .hit_o(class_hit)
  );

  always_comb begin
    done_d = chk_valid_i;
    exit_d = chk_valid_i & en_q & class_hit;
    code_d = chk_valid_i ? chk_code_i  : code_q;
    info_d = chk_valid_i ? chk_param_i : info_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      exit_q <= 1'b0;
      code_q <= '0;
      info_q <= '0;
    end else begin
      done_q <= done_d;
      exit_q <= exit_d;
      code_q <= code_d;
      info_q <= info_d;
    end
  end

  assign done_o      = done_q;
  assign exit_o      = exit_q;
  assign exit_code_o = code_q;
  assign exit_info_o = info_q;

  // R2: disabled intercepts never exit
  p_off_no_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid_i && !en_q) |=> !exit_o);

  // R8: exit only rides on a done strobe
  p_exit_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exit_o |-> done_o);

  // R8: done follows the request by one cycle
  p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid_i |=> done_o);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid_i |=> !done_o);

  // R9: code and info captured from the request
  p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid_i |=> (exit_code_o == $past(chk_code_i) &&
                     exit_info_o == $past(chk_param_i)));

  // R6: the ranged classes are claimed by at most one decoder slot
  p_one_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cls_hit));

  // R7: MSR with its general bit clear never exits
  p_msr_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid_i && chk_code_i == CODE_W'(MSR_CODE) && !gen_q[MSR_IDX])
      |=> !exit_o);
endmodule

// File: tb/intc_decide_top_tb.sv
module intc_decide_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_i, ld_enable_i, clear_i, chk_valid_i, msr_deny_i;
  logic [63:0] ld_gen_i, chk_param_i;
  logic [15:0] ld_cr_rd_i, ld_cr_wr_i, ld_dr_rd_i, ld_dr_wr_i;
  logic [31:0] ld_exc_i, chk_code_i;
  logic        done_o, exit_o;
  logic [31:0] exit_code_o;
  logic [63:0] exit_info_o;

  int n_cmp = 0;
  int n_bad = 0;

  // bench-side model of the intercept state
  logic        m_en;
  logic [63:0] m_gen;
  logic [15:0] m_crr, m_crw, m_drr, m_drw;
  logic [31:0] m_exc;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_decide_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .load_i(load_i), .ld_enable_i(ld_enable_i), .ld_gen_i(ld_gen_i),
    .ld_cr_rd_i(ld_cr_rd_i), .ld_cr_wr_i(ld_cr_wr_i),
    .ld_dr_rd_i(ld_dr_rd_i), .ld_dr_wr_i(ld_dr_wr_i),
    .ld_exc_i(ld_exc_i), .clear_i(clear_i),
    .chk_valid_i(chk_valid_i), .chk_code_i(chk_code_i),
    .chk_param_i(chk_param_i), .msr_deny_i(msr_deny_i),
    .done_o(done_o), .exit_o(exit_o),
    .exit_code_o(exit_code_o), .exit_info_o(exit_info_o)
  );

  task automatic cmp(input string req, input logic [63:0] act, input logic [63:0] exp,
                     input logic [31:0] code);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s code=%h actual=%h expected=%h", req, code, act, exp);
    end
  endtask

  function automatic string req_of(input logic [31:0] c);
    if (!m_en) return "R2";
    if (c < 32'h009 || (c >= 32'h010 && c < 32'h019)) return "R3";
    if ((c >= 32'h020 && c < 32'h028) || (c >= 32'h030 && c < 32'h038)) return "R4";
    if (c >= 32'h040 && c < 32'h060) return "R5";
    if (c == 32'h07C) return "R7";
    return "R6";
  endfunction

  function automatic logic model_exit(input logic [31:0] c, input logic d);
    if (!m_en) return 1'b0;
    if (c < 32'h009) return m_crr[c];
    if (c >= 32'h010 && c < 32'h019) return m_crw[c - 32'h010];
    if (c >= 32'h020 && c < 32'h028) return m_drr[c - 32'h020];
    if (c >= 32'h030 && c < 32'h038) return m_drw[c - 32'h030];
    if (c >= 32'h040 && c < 32'h060) return m_exc[c - 32'h040];
    if (c == 32'h07C) return m_gen[28] & d;
    if (c >= 32'h060 && c < 32'h0A0) return m_gen[c - 32'h060];
    return 1'b0;
  endfunction

  task automatic do_load(input logic en, input logic [63:0] gv, input logic [15:0] a,
                         input logic [15:0] b, input logic [15:0] c, input logic [15:0] d,
                         input logic [31:0] e);
    @(negedge clk);
    load_i = 1'b1; ld_enable_i = en; ld_gen_i = gv;
    ld_cr_rd_i = a; ld_cr_wr_i = b; ld_dr_rd_i = c; ld_dr_wr_i = d; ld_exc_i = e;
    @(negedge clk);
    load_i = 1'b0;
    m_en = en; m_gen = gv; m_crr = a; m_crw = b; m_drr = c; m_drw = d; m_exc = e;
  endtask

  task automatic do_check(input logic [31:0] c, input logic d);
    logic [63:0] p;
    p = {c ^ 32'h5A5A_0000, ~c};
    @(negedge clk);
    chk_valid_i = 1'b1; chk_code_i = c; chk_param_i = p; msr_deny_i = d;
    @(negedge clk);
    chk_valid_i = 1'b0; msr_deny_i = ~d;
    cmp(req_of(c), {63'd0, exit_o}, {63'd0, model_exit(c, d)}, c);
    cmp("R8", {63'd0, done_o}, 64'd1, c);
    cmp("R9", {exit_code_o, 32'd0} ^ 64'd0, {c, 32'd0}, c);
    cmp("R9", exit_info_o, p, c);
  endtask

  task automatic sweep(input logic d);
    for (int c = 0; c < 'hC0; c++) do_check(32'(c), d ^ c[0]);
    do_check(32'hFFFF_FFFF, d);
    do_check(32'h0001_0000, d);
    do_check(32'h8000_0040, d);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_i = 0; ld_enable_i = 0; ld_gen_i = 0; clear_i = 0;
    ld_cr_rd_i = 0; ld_cr_wr_i = 0; ld_dr_rd_i = 0; ld_dr_wr_i = 0; ld_exc_i = 0;
    chk_valid_i = 0; chk_code_i = 0; chk_param_i = 0; msr_deny_i = 0;
    m_en = 0; m_gen = 0; m_crr = 0; m_crw = 0; m_drr = 0; m_drw = 0; m_exc = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    cmp("R1", {62'd0, done_o, exit_o}, 64'd0, 0);
    cmp("R1", {exit_code_o, 32'd0}, 64'd0, 0);
    cmp("R1", exit_info_o, 64'd0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1", {62'd0, done_o, exit_o}, 64'd0, 0);

    // R1: after reset, registers empty -> nothing exits even for MSR with deny
    sweep(1'b1);

    // R2: masks full but enable off
    do_load(1'b0, '1, '1, '1, '1, '1, '1);
    sweep(1'b1);

    // pattern A: bits beyond each class span deliberately set
    do_load(1'b1, 64'hF0F0_1234_5678_9ABC, 16'hFE55, 16'hFFAA, 16'hFF5A, 16'hFFC3,
            32'hA5A5_0F0F);
    sweep(1'b0);
    sweep(1'b1);
    // pattern B: complement
    do_load(1'b1, ~64'hF0F0_1234_5678_9ABC, ~16'hFE55, ~16'hFFAA, ~16'hFF5A,
            ~16'hFFC3, ~32'hA5A5_0F0F);
    sweep(1'b0);
    // R7 explicit: general bit 28 clear, deny high
    do_check(32'h07C, 1'b1);
    cmp("R7", {63'd0, exit_o}, 64'd0, 32'h07C);

    // R8: done drops when idle
    @(negedge clk);
    cmp("R8", {62'd0, done_o, exit_o}, 64'd0, 0);
    cmp("R9", {exit_code_o, 32'd0}, {32'h07C, 32'd0}, 32'h07C);

    // R10: check coincident with load uses old state (B), then new (all ones)
    @(negedge clk);
    load_i = 1; ld_enable_i = 1; ld_gen_i = '1; ld_cr_rd_i = '1; ld_cr_wr_i = '1;
    ld_dr_rd_i = '1; ld_dr_wr_i = '1; ld_exc_i = '1;
    chk_valid_i = 1; chk_code_i = 32'h000; chk_param_i = 64'h1; msr_deny_i = 0;
    @(negedge clk);
    load_i = 0; chk_valid_i = 0;
    cmp("R10", {63'd0, exit_o}, {63'd0, ~16'hFE55 & 16'h1}, 32'h000);
    m_en = 1; m_gen = '1; m_crr = '1; m_crw = '1; m_drr = '1; m_drw = '1; m_exc = '1;
    do_check(32'h000, 1'b0);
    cmp("R10", {63'd0, exit_o}, 64'd1, 32'h000);

    // R11: clear, then every code silent
    @(negedge clk); clear_i = 1;
    @(negedge clk); clear_i = 0;
    m_en = 0; m_gen = 0; m_exc = 0;
    sweep(1'b1);

    // R11: clear beats a coincident load
    @(negedge clk);
    clear_i = 1; load_i = 1; ld_enable_i = 1; ld_gen_i = '1; ld_exc_i = '1;
    @(negedge clk);
    clear_i = 0; load_i = 0;
    do_check(32'h045, 1'b1);
    cmp("R11", {63'd0, exit_o}, 64'd0, 32'h045);
    do_check(32'h061, 1'b1);
    cmp("R11", {63'd0, exit_o}, 64'd0, 32'h061);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule